// File: doc/BRIEF.md
# RGB to YCbCr 4:4:4 Colour-Space Converter

This block converts a stream of RGB pixels into full-resolution YCbCr. Each clock it accepts one 24-bit pixel with 8 bits per colour, together with the frame sync, line sync and pixel-valid strobes. A fixed number of cycles later it emits a 24-bit pixel that carries its own luma and both chroma differences. Every input position gets its own output sample, and no chroma is shared between neighbours.

The arithmetic uses constant fixed-point coefficients scaled by 1024. The three products for each output channel are summed and then rounded to nearest. The result is then clamped into the 8-bit range. The sync and valid strobes travel through a delay line of the same length as the datapath, so a downstream consumer sees timing that is aligned with the converted pixel. The pipeline never stalls. The block sits between a video source and any stage that works in YCbCr.

Top module: `rgb2ycc_top`

## Requirements
- R1: Y equals (306·R + 601·G + 117·B + 512) >> 10, where >> is a floor (arithmetic) shift.
- R2: Cb equals (−176·R − 347·G + 523·B + 128·1024 + 512) >> 10, then clamped.
- R3: Cr equals (523·R − 438·G − 85·B + 128·1024 + 512) >> 10, then clamped.
- R4: Any channel result above 255 is output as 255. For example, pure blue gives Cb = 255.
- R5: Any channel result below 0 is output as 0. For example, yellow gives Cb = 0 and cyan gives Cr = 0.
- R6: The input word carries R in bits [23:16], G in [15:8] and B in [7:0]. The output word carries Y in [23:16], Cb in [15:8] and Cr in [7:0].
- R7: A pixel presented at one rising edge appears on the output after the third rising edge. Back-to-back pixels are accepted every cycle, and one output is produced per input.
- R8: The valid, line-sync and frame-sync outputs equal the matching inputs delayed by exactly 3 clock cycles.
- R9: An active-low asynchronous reset forces the valid, line-sync and frame-sync outputs to 0 at once.
- R10: When input valid is low, the pipeline still advances. The output valid is low in the matching output cycle, and the pixel value still passes through converted.
- R11: A grey input (R = G = B = v) yields Y = v and Cb = Cr = 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| iVsync | input | 1 | Frame sync in |
| iHsync | input | 1 | Line sync in |
| iValid | input | 1 | Pixel valid in |
| iRgb | input | 24 | R[23:16], G[15:8], B[7:0] |
| oVsync | output | 1 | Frame sync, delayed 3 cycles |
| oHsync | output | 1 | Line sync, delayed 3 cycles |
| oValid | output | 1 | Pixel valid, delayed 3 cycles |
| oYcc | output | 24 | Y[23:16], Cb[15:8], Cr[7:0] |

## Verification
The bench drives the primaries and secondaries, because those colours push the chroma sums past 255 or below 0. A design that wrapped instead of clamping would turn pure blue's Cb into a small number, and yellow's Cb into a value near 255. Grey and odd mixed values catch a design that truncates instead of rounding, or that shifts logically instead of arithmetically; either would be off by one, or wildly off for negative sums. Valid gaps and sync pulses placed at different positions in the stream expose a timing delay line whose length does not match the datapath. A reset issued in the middle of the stream catches outputs that are only cleared synchronously.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int COMP_W    = 8;
  localparam int NUM_CH    = 3;
  localparam int FRAC_BITS = 10;
  localparam int COEF_W    = 12;
  localparam int PIPE_LAT  = 3;
  localparam int PIX_W     = NUM_CH * COMP_W;

  typedef logic [COMP_W-1:0] comp_t;

  typedef struct packed {
    logic vsync;
    logic hsync;
    logic valid;
  } vtag_t;

  // channel 0 = Y, 1 = Cb, 2 = Cr; source 0 = R, 1 = G, 2 = B
  function automatic int coefOf(int ch, int src);
    int k;
    k = 0;
    case (ch)
      0: case (src) 0: k = 306;  1: k = 601;  default: k = 117; endcase
      1: case (src) 0: k = -176; 1: k = -347; default: k = 523; endcase
      default: case (src) 0: k = 523; 1: k = -438; default: k = -85; endcase
    endcase
    return k;
  endfunction

  function automatic int biasOf(int ch);
    return (ch == 0) ? 0 : 128;
  endfunction
endpackage

// File: rtl/ycc_channel.sv
module ycc_channel
  import ycc_pkg::*;
#(
  parameter int K_R  = 0,
  parameter int K_G  = 0,
  parameter int K_B  = 0,
  parameter int BIAS = 0
) (
  input  logic  clk,
  input  comp_t rIn,
  input  comp_t gIn,
  input  comp_t bIn,
  output comp_t cOut
);
  localparam int PROD_W = COMP_W + COEF_W;
  localparam int SUM_W  = PROD_W + 2;
  localparam int KS [NUM_CH] = '{K_R, K_G, K_B};
  localparam logic signed [SUM_W-1:0] ADD_K =
    SUM_W'((BIAS <<< FRAC_BITS) + (1 <<< (FRAC_BITS - 1)));
  localparam logic signed [SUM_W-1:0] TOP_V = SUM_W'((1 << COMP_W) - 1);

  comp_t srcs [NUM_CH];
  assign srcs[0] = rIn;
  assign srcs[1] = gIn;
  assign srcs[2] = bIn;

  // stage 1: one registered product per source
  for (genvar s = 0; s < NUM_CH; s++) begin : g_mul
    localparam logic signed [PROD_W-1:0] KEXT = PROD_W'(KS[s]);
    logic signed [PROD_W-1:0] srcExt;
    logic signed [PROD_W-1:0] prodQ;
    assign srcExt = signed'(PROD_W'(srcs[s]));
    always_ff @(posedge clk) prodQ <= srcExt * KEXT;
  end

  // stage 2: sum plus offset plus half LSB
  logic signed [SUM_W-1:0] sumQ;
  always_ff @(posedge clk)
    sumQ <= SUM_W'(g_mul[0].prodQ) + SUM_W'(g_mul[1].prodQ)
          + SUM_W'(g_mul[2].prodQ) + ADD_K;

  // stage 3: scale down and saturate
  logic signed [SUM_W-1:0] scaled;
  assign scaled = sumQ >>> FRAC_BITS;

  comp_t outQ;
  always_ff @(posedge clk) begin
    if (scaled < 0)           outQ <= '0;
    else if (scaled > TOP_V)  outQ <= '1;
    else                      outQ <= scaled[COMP_W-1:0];
  end
  assign cOut = outQ;
endmodule

// File: rtl/ycc_datapath.sv
module ycc_datapath
  import ycc_pkg::*;
(
  input  logic             clk,
  input  logic [PIX_W-1:0] rgbIn,
  output logic [PIX_W-1:0] yccOut
);
  comp_t src [NUM_CH];
  for (genvar s = 0; s < NUM_CH; s++) begin : g_unpack
    assign src[s] = rgbIn[(NUM_CH-1-s)*COMP_W +: COMP_W];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    comp_t res;
    ycc_channel #(
      .K_R (coefOf(c, 0)),
      .K_G (coefOf(c, 1)),
      .K_B (coefOf(c, 2)),
      .BIAS(biasOf(c))
    ) u_ch (
      .clk (clk),
      .rIn (src[0]),
      .gIn (src[1]),
      .bIn (src[2]),
      .cOut(res)
    );
    assign yccOut[(NUM_CH-1-c)*COMP_W +: COMP_W] = res;
  end
endmodule

// File: rtl/ycc_timing.sv
module ycc_timing
  import ycc_pkg::*;
#(
  parameter int DEPTH = PIPE_LAT
) (
  input  logic  clk,
  input  logic  rstN,
  input  vtag_t tagIn,
  output vtag_t tagOut
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    vtag_t tagQ;
    vtag_t tagD;
    if (i == 0) begin : g_first
      assign tagD = tagIn;
    end else begin : g_next
      assign tagD = g_stg[i-1].tagQ;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tagQ <= '0;
      else       tagQ <= tagD;
    end
  end
  assign tagOut = g_stg[DEPTH-1].tagQ;
endmodule

// File: rtl/rgb2ycc_top.sv
module rgb2ycc_top
  import ycc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        iVsync,
  input  logic        iHsync,
  input  logic        iValid,
  input  logic [23:0] iRgb,
  output logic        oVsync,
  output logic        oHsync,
  output logic        oValid,
  output logic [23:0] oYcc
);
  vtag_t tagIn, tagOut;
  assign tagIn = '{vsync: iVsync, hsync: iHsync, valid: iValid};

  ycc_timing #(.DEPTH(PIPE_LAT)) u_timing (
    .clk   (clk),
    .rstN  (rstN),
    .tagIn (tagIn),
    .tagOut(tagOut)
  );

  ycc_datapath u_dp (
    .clk   (clk),
    .rgbIn (iRgb),
    .yccOut(oYcc)
  );

  assign oVsync = tagOut.vsync;
  assign oHsync = tagOut.hsync;
  assign oValid = tagOut.valid;
endmodule

// File: rtl/ycc_checker.sv
module ycc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        iVsync,
  input logic        iHsync,
  input logic        iValid,
  input logic [23:0] iRgb,
  input logic        oVsync,
  input logic        oHsync,
  input logic        oValid,
  input logic [23:0] oYcc
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |-> (oValid == $past(iValid, 3))); // R8
  AST_HSYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |-> (oHsync == $past(iHsync, 3))); // R8
  AST_VSYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |-> (oVsync == $past(iVsync, 3))); // R8
  AST_GREY_NEUTRAL: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && $past(iRgb[23:16] == iRgb[15:8] && iRgb[15:8] == iRgb[7:0], 3))
    |-> (oYcc[23:16] == $past(iRgb[23:16], 3) && oYcc[15:0] == 16'h8080)); // R11
  AST_BLUE_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && $past(iRgb == 24'h0000FF, 3)) |-> (oYcc[15:8] == 8'hFF)); // R4
  AST_YELLOW_FLOORS: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && $past(iRgb == 24'hFFFF00, 3)) |-> (oYcc[15:8] == 8'h00)); // R5
endmodule

bind rgb2ycc_top ycc_checker u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .iVsync(iVsync),
  .iHsync(iHsync),
  .iValid(iValid),
  .iRgb  (iRgb),
  .oVsync(oVsync),
  .oHsync(oHsync),
  .oValid(oValid),
  .oYcc  (oYcc)
);

// File: tb/sim_rgb2ycc_top.sv
`timescale 1ns/1ps
module sim_rgb2ycc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        iVsync = 1'b0, iHsync = 1'b0, iValid = 1'b0;
  logic [23:0] iRgb = '0;
  logic        oVsync, oHsync, oValid;
  logic [23:0] oYcc;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  rgb2ycc_top u0 (
    .clk(clk), .rstN(rstN), .iVsync(iVsync), .iHsync(iHsync),
    .iValid(iValid), .iRgb(iRgb), .oVsync(oVsync), .oHsync(oHsync),
    .oValid(oValid), .oYcc(oYcc)
  );

  typedef struct packed {
    logic [23:0] rgb;
    logic        v;
    logic        h;
    logic        s;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    {24'h000000, 1'b1, 1'b0, 1'b1},
    {24'hFFFFFF, 1'b1, 1'b0, 1'b0},
    {24'hFF0000, 1'b1, 1'b1, 1'b0},
    {24'h00FF00, 1'b1, 1'b0, 1'b0},
    {24'h0000FF, 1'b0, 1'b0, 1'b0},
    {24'hFFFF00, 1'b1, 1'b0, 1'b0},
    {24'h808080, 1'b1, 1'b0, 1'b0},
    {24'h10EB80, 1'b1, 1'b1, 1'b0},
    {24'h00FFFF, 1'b0, 1'b1, 1'b0},
    {24'hFF00FF, 1'b1, 1'b0, 1'b0},
    {24'h3C7A1E, 1'b1, 1'b0, 1'b1},
    {24'hC8641E, 1'b1, 1'b0, 1'b0}
  };

  function automatic int rawOf(int ch, int r, int g, int b);
    int kr, kg, kb, off, s;
    case (ch)
      0: begin kr = 306;  kg = 601;  kb = 117; off = 0;   end
      1: begin kr = -176; kg = -347; kb = 523; off = 128; end
      default: begin kr = 523; kg = -438; kb = -85; off = 128; end
    endcase
    s = kr*r + kg*g + kb*b + off*1024 + 512;
    return (s + 256*1024) / 1024 - 256;
  endfunction

  function automatic int clampOf(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkPixel(logic [23:0] rgb, logic [23:0] got);
    int r, g, b;
    r = int'(rgb[23:16]); g = int'(rgb[15:8]); b = int'(rgb[7:0]);
    for (int c = 0; c < 3; c++) begin
      int raw, act;
      string tag;
      raw = rawOf(c, r, g, b);
      act = int'(got[(2-c)*8 +: 8]);
      if (raw > 255)      tag = "R4 high clamp";
      else if (raw < 0)   tag = "R5 low clamp";
      else if (r == g && g == b) tag = "R11 grey";
      else if (c == 0)    tag = "R1 luma";
      else if (c == 1)    tag = "R2 blue diff";
      else                tag = "R3 red diff";
      check(tag, act, clampOf(raw));
    end
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int inCount, outCount;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid in reset", int'(oValid), 0);
    check("R9 hsync in reset", int'(oHsync), 0);
    check("R9 vsync in reset", int'(oVsync), 0);
    rstN = 1'b1;

    // main stream, back to back (R7, R8, R10)
    inCount = 0;
    outCount = 0;
    for (int i = 0; i < NV + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        vec_t e;
        e = VECS[i-3];
        check("R8 valid delay", int'(oValid), int'(e.v));
        check("R8 hsync delay", int'(oHsync), int'(e.h));
        check("R8 vsync delay", int'(oVsync), int'(e.s));
        if (!e.v) check("R10 valid low passes", int'(oValid), 0);
        checkPixel(e.rgb, oYcc);
        if (oValid) outCount++;
      end
      if (i < NV) begin
        iRgb   = VECS[i].rgb;
        iValid = VECS[i].v;
        iHsync = VECS[i].h;
        iVsync = VECS[i].s;
        if (VECS[i].v) inCount++;
      end else begin
        iRgb = '0; iValid = 1'b0; iHsync = 1'b0; iVsync = 1'b0;
      end
    end
    check("R7 one output per input", outCount, inCount);

    // R6 field positions: pure red, Y=76 in [23:16], Cb=84 in [15:8], Cr=255 in [7:0]
    iRgb = 24'hFF0000; iValid = 1'b1;
    @(negedge clk);
    iRgb = 24'h000000; iValid = 1'b0;
    @(negedge clk);
    check("R7 not yet at 2 cycles", int'(oValid), 0);
    @(negedge clk);
    check("R7 arrives at 3 cycles", int'(oValid), 1);
    check("R6 luma field", int'(oYcc[23:16]), 76);
    check("R6 blue diff field", int'(oYcc[15:8]), 84);
    check("R6 red diff field", int'(oYcc[7:0]), 255);

    // R9 asynchronous reset mid-stream
    iValid = 1'b1; iHsync = 1'b1; iVsync = 1'b1; iRgb = 24'h123456;
    repeat (4) @(negedge clk);
    check("R9 outputs high before reset", int'(oValid & oHsync & oVsync), 1);
    rstN = 1'b0;
    #1;
    check("R9 async valid clear", int'(oValid), 0);
    check("R9 async hsync clear", int'(oHsync), 0);
    check("R9 async vsync clear", int'(oVsync), 0);
    @(negedge clk);
    iValid = 1'b0; iHsync = 1'b0; iVsync = 1'b0;
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 stays clear after release", int'(oValid | oHsync | oVsync), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule